// File: doc/BRIEF.md
# Dual-Oversampling Baud Divisor Selector

This block turns a requested bit rate into a 16-bit clock divisor for a serial transmitter and receiver. It runs from a fixed functional clock (a parameter, 48 MHz by default). For each request it works out the nearest divisor for 13x and for 16x oversampling. It then computes the bit rate that each divisor actually gives and keeps the mode whose rate lies closer to the request. The chosen divisor then drives a free-running tick generator, which sends out one oversample tick every `div_o` clock cycles.

A request is a one-cycle `start_i` pulse with `baud_i` valid in the same cycle. A single shared restoring divider does all the arithmetic, one quotient bit per cycle, so every request finishes after the same number of cycles and then raises `done_o` for one cycle. Software may also bypass the search and load a divisor and mode directly through the override input.

Top module: `baud_mode_picker`

## Requirements
- R1: After reset, `div_o` is 0xFFFF, `mode13_o` is 0 (16x), and `busy_o` and `done_o` are both 0.
- R2: For oversampling factor k in {13, 16}, the candidate divisor is floor((CLK_HZ + floor(k*baud/2)) / (k*baud)), which is the quotient rounded to the nearest integer.
- R3: Each candidate's error is |baud - floor(CLK_HZ / (k*divisor))|. The block selects 13x only when the 13x error is strictly smaller than the 16x error, so a tie selects 16x. On `mode13_o`, 1 means 13x and 0 means 16x, and `div_o` carries the divisor of the selected mode.
- R4: When `start_i` is sampled at a clock edge with the block idle, `busy_o` is high from the next cycle onward. `done_o` is high for exactly one cycle, after edge 4*(NUM_W+1)+1 counted from that edge (edge 133 with defaults), and `busy_o` is low in that same cycle.
- R5: A `start_i` pulse that arrives while `busy_o` is high is ignored. The baud value already latched for the running request is the one that gets used.
- R6: Every divisor the block produces lies in the range 1 to 0xFFFF. A rounded quotient of 0 becomes 1. A quotient above 0xFFFF, which happens for rates below CLK_HZ/16/65535 and also for a baud of 0, becomes 0xFFFF.
- R7: An `ovr_i` pulse seen while idle, with no `start_i` in the same cycle, loads `div_o` from `ovr_val_i[15:0]` (0 is loaded as 1) and `mode13_o` from `ovr_val_i[16]`, effective in the next cycle. It does not raise `done_o`. While `busy_o` is high, `ovr_i` is ignored.
- R8: `tick_o` is a one-cycle pulse, and consecutive pulses are exactly `div_o` cycles apart.
- R9: A new `div_o` value does not affect the period that is already running. The tick generator reads the divisor only at a reload, so the first period after a change still has the old length.
- R10: `div_o` and `mode13_o` hold their values throughout a computation and change only when `done_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to compute a divisor for `baud_i` |
| baud_i | input | BAUD_W (24) | Requested bit rate in bits per second |
| ovr_i | input | 1 | One-cycle request to load `ovr_val_i` directly |
| ovr_val_i | input | 17 | Override value: divisor in bits 15:0, 13x select in bit 16 |
| busy_o | output | 1 | High while a computation is in progress |
| done_o | output | 1 | One-cycle pulse when a new result is on the outputs |
| div_o | output | 16 | Active clock divisor |
| mode13_o | output | 1 | 1 selects 13x oversampling, 0 selects 16x |
| tick_o | output | 1 | Oversample tick, one pulse per divisor period |

## Verification
On every cycle, the assertions check the following: `done_o` lasts exactly one cycle, an idle start always raises busy, the divisor never reaches zero, the latched baud and the outputs hold steady during a run, and a tick never follows a non-zero count. Only the bench scenarios can show that the chosen divisor and mode are right for real rates. These include the 115200 case, where both modes have the same error, the 921600 case, where 13x wins, and the saturating low and high extremes. The same applies to the fixed latency, to requests ignored while busy, and to a divisor change leaving the running tick period untouched.

// File: rtl/bdsel_pkg.sv
package bdsel_pkg;
    localparam int DIV_W  = 16;
    localparam int OVS_LO = 13;
    localparam int OVS_HI = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_STEP = 2'd2,
        ST_PICK = 2'd3
    } bdsel_st_e;
endpackage

// File: rtl/bdsel_divstep.sv
// One restoring-division step: shift in the next dividend bit and subtract if it fits.
module bdsel_divstep #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] den_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] acc_o
);
    logic [W:0] shifted;
    logic [W:0] diff;
    logic       fits;

    always_comb begin
        shifted = {rem_i, acc_i[W-1]};
        diff    = shifted - {1'b0, den_i};
        fits    = (shifted >= {1'b0, den_i});
        rem_o   = fits ? diff[W-1:0] : shifted[W-1:0];
        acc_o   = {acc_i[W-2:0], fits};
    end
endmodule

// File: rtl/bdsel_ctrl.sv
// Sequencer: four divisions on one shared divider, then the mode decision.
module bdsel_ctrl
    import bdsel_pkg::*;
#(
    parameter int CLK_HZ = 48_000_000,
    parameter int BAUD_W = 24,
    parameter int NUM_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BAUD_W-1:0] baud_i,
    input  logic              ovr_i,
    input  logic [DIV_W:0]    ovr_val_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              mode13_o
);
    localparam int CNT_W   = $clog2(NUM_W + 1);
    localparam int MAX_DIV = (1 << DIV_W) - 1;
    localparam logic [NUM_W-1:0] CLK_N = NUM_W'(CLK_HZ);

    typedef struct packed {
        bdsel_st_e         st;
        logic [1:0]        ph;
        logic [CNT_W-1:0]  cnt;
        logic [BAUD_W-1:0] baud;
        logic [NUM_W-1:0]  rem;
        logic [NUM_W-1:0]  acc;
        logic [NUM_W-1:0]  den;
        logic [NUM_W-1:0]  r13;
        logic [NUM_W-1:0]  r16;
        logic [DIV_W-1:0]  d13;
        logic [DIV_W-1:0]  d16;
        logic [DIV_W-1:0]  div;
        logic              mode13;
        logic              done;
    } ctrl_t;

    ctrl_t q, d;

    logic [NUM_W-1:0] stp_rem, stp_acc;
    logic [NUM_W-1:0] ld_num, ld_den;
    logic [NUM_W-1:0] baud_n, e13, e16;

    function automatic logic [DIV_W-1:0] clamp_div(input logic [NUM_W-1:0] v);
        if (v == '0)
            return DIV_W'(1);
        else if (v > NUM_W'(MAX_DIV))
            return '1;
        else
            return v[DIV_W-1:0];
    endfunction

    bdsel_divstep #(.W(NUM_W)) u_step (
        .rem_i (q.rem),
        .acc_i (q.acc),
        .den_i (q.den),
        .rem_o (stp_rem),
        .acc_o (stp_acc)
    );

    // Operand selection per phase: two rounded divisors, then two achieved rates.
    always_comb begin
        unique case (q.ph)
            2'd0: begin
                ld_den = NUM_W'(q.baud) * NUM_W'(OVS_LO);
                ld_num = CLK_N + (ld_den >> 1);
            end
            2'd1: begin
                ld_den = NUM_W'(q.baud) * NUM_W'(OVS_HI);
                ld_num = CLK_N + (ld_den >> 1);
            end
            2'd2: begin
                ld_den = NUM_W'(q.d13) * NUM_W'(OVS_LO);
                ld_num = CLK_N;
            end
            default: begin
                ld_den = NUM_W'(q.d16) * NUM_W'(OVS_HI);
                ld_num = CLK_N;
            end
        endcase
    end

    always_comb begin
        baud_n = NUM_W'(q.baud);
        e13    = (baud_n > q.r13) ? baud_n - q.r13 : q.r13 - baud_n;
        e16    = (baud_n > q.r16) ? baud_n - q.r16 : q.r16 - baud_n;
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.baud = baud_i;
                    d.ph   = 2'd0;
                    d.st   = ST_LOAD;
                end else if (ovr_i) begin
                    d.div    = (ovr_val_i[DIV_W-1:0] == '0) ? DIV_W'(1)
                                                            : ovr_val_i[DIV_W-1:0];
                    d.mode13 = ovr_val_i[DIV_W];
                end
            end
            ST_LOAD: begin
                d.acc = ld_num;
                d.den = ld_den;
                d.rem = '0;
                d.cnt = CNT_W'(NUM_W);
                d.st  = ST_STEP;
            end
            ST_STEP: begin
                d.rem = stp_rem;
                d.acc = stp_acc;
                d.cnt = q.cnt - CNT_W'(1);
                if (q.cnt == CNT_W'(1)) begin
                    unique case (q.ph)
                        2'd0:    d.d13 = clamp_div(stp_acc);
                        2'd1:    d.d16 = clamp_div(stp_acc);
                        2'd2:    d.r13 = stp_acc;
                        default: d.r16 = stp_acc;
                    endcase
                    if (q.ph == 2'd3) begin
                        d.st = ST_PICK;
                    end else begin
                        d.ph = q.ph + 2'd1;
                        d.st = ST_LOAD;
                    end
                end
            end
            default: begin
                d.mode13 = (e13 < e16);
                d.div    = (e13 < e16) ? q.d13 : q.d16;
                d.done   = 1'b1;
                d.st     = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.div <= '1;
        end else begin
            q <= d;
        end
    end

    assign busy_o   = (q.st != ST_IDLE);
    assign done_o   = q.done;
    assign div_o    = q.div;
    assign mode13_o = q.mode13;

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    // R4
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && q.st == ST_IDLE) |=> busy_o);

    // R5
    baud_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |=> $stable(q.baud));

    // R10
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LOAD || q.st == ST_STEP) |=> ($stable(q.div) && $stable(q.mode13)));

    // R6
    div_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.div != '0);
endmodule

// File: rtl/bdsel_tick.sv
// Oversample tick: count down from divisor-1, pulse and reload at zero.
module bdsel_tick
    import bdsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } tick_t;

    tick_t q, d;

    always_comb begin
        d = q;
        if (q.cnt == '0) begin
            d.cnt  = div_i - DIV_W'(1);
            d.tick = 1'b1;
        end else begin
            d.cnt  = q.cnt - DIV_W'(1);
            d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick_o = q.tick;

    // R8
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt != '0) |=> !q.tick);
endmodule

// File: rtl/baud_mode_picker.sv
module baud_mode_picker
    import bdsel_pkg::*;
#(
    parameter int CLK_HZ = 48_000_000,
    parameter int BAUD_W = 24,
    parameter int NUM_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BAUD_W-1:0] baud_i,
    input  logic              ovr_i,
    input  logic [16:0]       ovr_val_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [15:0]       div_o,
    output logic              mode13_o,
    output logic              tick_o
);
    logic [DIV_W-1:0] div_w;

    bdsel_ctrl #(
        .CLK_HZ (CLK_HZ),
        .BAUD_W (BAUD_W),
        .NUM_W  (NUM_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .baud_i    (baud_i),
        .ovr_i     (ovr_i),
        .ovr_val_i (ovr_val_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .div_o     (div_w),
        .mode13_o  (mode13_o)
    );

    bdsel_tick u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (div_w),
        .tick_o (tick_o)
    );

    assign div_o = div_w;
endmodule

// File: tb/sim_baud_mode_picker.sv
`timescale 1ns/1ps
module sim_baud_mode_picker;
    localparam longint CLK_HZ = 48_000_000;
    localparam int     NUM_W  = 32;
    localparam int     LAT    = 4 * (NUM_W + 1) + 1;
    localparam int     WD     = 150_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [23:0] baud_i = '0;
    logic        ovr_i = 1'b0;
    logic [16:0] ovr_val_i = '0;
    logic        busy_o, done_o, mode13_o, tick_o;
    logic [15:0] div_o;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    typedef struct {
        int unsigned dv;
        bit          m13;
        string       tag;
    } exp_t;
    exp_t sb[$];

    baud_mode_picker u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .baud_i(baud_i),
        .ovr_i(ovr_i), .ovr_val_i(ovr_val_i), .busy_o(busy_o), .done_o(done_o),
        .div_o(div_o), .mode13_o(mode13_o), .tick_o(tick_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) if (cyc == WD) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, WD);
        finish_run();
    end

    function automatic longint rnd_div(input longint n, input longint dn);
        if (dn == 0) return 64'hFFFF_FFFF;
        return (n + dn / 2) / dn;
    endfunction

    function automatic longint clampd(input longint v);
        if (v == 0) return 1;
        if (v > 65535) return 65535;
        return v;
    endfunction

    // R2 R3 R6: model of the selection rule
    function automatic void ref_pick(input longint b, output int unsigned dv, output bit m13);
        longint d13, d16, e13, e16;
        d13 = clampd(rnd_div(CLK_HZ, 13 * b));
        d16 = clampd(rnd_div(CLK_HZ, 16 * b));
        e13 = b - CLK_HZ / (13 * d13);
        e16 = b - CLK_HZ / (16 * d16);
        if (e13 < 0) e13 = -e13;
        if (e16 < 0) e16 = -e16;
        m13 = (e13 < e16);
        dv  = m13 ? int'(d13) : int'(d16);
    endfunction

    // Monitor: pop and compare on every done pulse
    always @(negedge clk) if (rst_n && done_o) begin
        exp_t e;
        if (sb.size() == 0) begin
            chk(0, "R4 unexpected done", 1, 0);
        end else begin
            e = sb.pop_front();
            chk(div_o == e.dv[15:0], {e.tag, " divisor"}, div_o, e.dv);
            chk(mode13_o == e.m13, {e.tag, " mode"}, mode13_o, e.m13);
        end
    end

    // Driver: push expectation, issue request, optionally disturb while busy
    task automatic run_baud(input int unsigned b, input string tag, input bit disturb);
        exp_t e;
        int n;
        logic [15:0] div0;
        logic m0;
        ref_pick(b, e.dv, e.m13);
        e.tag = tag;
        sb.push_back(e);
        div0 = div_o;
        m0   = mode13_o;
        @(negedge clk);
        start_i = 1'b1;
        baud_i  = b[23:0];
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R4 busy after start", busy_o, 1);
        n = 0;
        while (!done_o && n < 1000) begin
            if (div_o != div0 || mode13_o != m0) begin
                chk(0, "R10 outputs moved while busy", div_o, div0);
                div0 = div_o;
                m0   = mode13_o;
            end
            if (disturb && n == 10) begin
                start_i = 1'b1;
                baud_i  = 24'd300;
            end else if (disturb && n == 20) begin
                ovr_i     = 1'b1;
                ovr_val_i = 17'h1_0007;
            end else begin
                start_i = 1'b0;
                ovr_i   = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start_i = 1'b0;
        ovr_i   = 1'b0;
        chk(n == LAT, "R4 latency", n, LAT);
        chk(busy_o == 1'b0, "R4 idle with done", busy_o, 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R4 done one cycle", done_o, 0);
    endtask

    task automatic do_override(input logic [16:0] v);
        @(negedge clk);
        ovr_i     = 1'b1;
        ovr_val_i = v;
        @(negedge clk);
        ovr_i = 1'b0;
    endtask

    task automatic wait_tick(output int t);
        int g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!tick_o && g < 70000);
        t = cyc;
    endtask

    initial begin
        int ta, tb, tc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(div_o == 16'hFFFF, "R1 reset divisor", div_o, 16'hFFFF);
        chk(mode13_o == 1'b0, "R1 reset mode", mode13_o, 0);
        chk(busy_o == 1'b0 && done_o == 1'b0, "R1 reset busy/done", {busy_o, done_o}, 0);

        // R2 R3 over standard rates
        run_baud(9600,    "R2 9600", 0);
        run_baud(115200,  "R3 115200 tie", 0);
        chk(div_o == 16'd26 && mode13_o == 1'b0, "R3 tie picks 16x div 26", div_o, 26);
        run_baud(230400,  "R2 230400", 0);
        run_baud(460800,  "R2 460800", 0);
        run_baud(921600,  "R3 921600", 0);
        chk(div_o == 16'd4 && mode13_o == 1'b1, "R3 13x wins div 4", div_o, 4);
        run_baud(3000000, "R2 3000000", 0);
        chk(div_o == 16'd1 && mode13_o == 1'b0, "R2 3M div 1 16x", div_o, 1);

        // R6 extremes
        run_baud(40, "R6 low rate", 0);
        chk(div_o == 16'hFFFF, "R6 saturate high", div_o, 16'hFFFF);
        run_baud(0, "R6 zero baud", 0);
        run_baud(16000000, "R6 clamp to one", 0);
        chk(div_o == 16'd1, "R6 clamp to one", div_o, 1);

        // R5 R7: start and override during busy are ignored
        run_baud(57600, "R5 ignore while busy", 1);

        // R7 override
        do_override(17'h1_0005);
        chk(div_o == 16'd5 && mode13_o == 1'b1, "R7 override load", div_o, 5);
        chk(done_o == 1'b0, "R7 no done on override", done_o, 0);
        do_override(17'h0_0000);
        chk(div_o == 16'd1 && mode13_o == 1'b0, "R7 override zero", div_o, 1);

        // R8 tick period and width
        do_override(17'd5);
        wait_tick(ta);
        wait_tick(ta);
        @(negedge clk);
        chk(tick_o == 1'b0, "R8 tick width", tick_o, 0);
        wait_tick(tb);
        chk(tb - ta == 5, "R8 tick period", tb - ta, 5);

        // R9 change takes effect at next reload
        do_override(17'd20);
        wait_tick(ta);
        wait_tick(ta);
        repeat (2) @(negedge clk);
        ovr_i = 1'b1;
        ovr_val_i = 17'd3;
        @(negedge clk);
        ovr_i = 1'b0;
        wait_tick(tb);
        chk(tb - ta == 20, "R9 old period completes", tb - ta, 20);
        wait_tick(tc);
        chk(tc - tb == 3, "R8 new period", tc - tb, 3);

        chk(sb.size() == 0, "R4 all results seen", sb.size(), 0);
        finish_run();
    end
endmodule